// File: doc/BRIEF.md
# SDRAM Power-Up Bring-Up Sequencer

This block owns the SDRAM command bus from reset until the memory is ready for normal traffic. After reset it drives a fixed bring-up order. It sends NOP for a power-up settling window, then a PRECHARGE that closes every bank. Next come a set number of AUTO REFRESH commands, and then one LOAD MODE REGISTER that carries an op-code built from parameters. Each command is followed by its own minimum idle gap before the next one.

Once the mode-register delay has run out, the block raises a done flag. In the same cycle its output multiplexer hands the command pins, address, bank and clock enable to the normal access controller. The settling window is set in microseconds and turned into cycles from a clock-frequency parameter. A separate cycle-count override shortens the window for simulation. All inter-command gaps are cycle-count parameters.

Top module: `sdram_bringup_seq`

## Requirements
- R1: While reset is asserted, the bus shows NOP (select low, row strobe, column strobe and write enable high, encoded {cs,ras,cas,we} = 0111), clock enable is high, address and bank are zero and `init_done` is low.
- R2: After reset is released, the bus carries only NOP for exactly W cycles, where W = SIM_WAIT_CYC when that is non-zero and CLK_MHZ*PWRUP_US otherwise. The first command appears on the W-th rising edge after release.
- R3: The first command is PRECHARGE (encoding 0010) with address bit 10 high and all other address and bank bits zero. The next command follows exactly T_RP_CYC cycles later.
- R4: Exactly REF_N AUTO REFRESH commands (encoding 0001, address and bank zero) follow the precharge. Each is followed by exactly T_RFC_CYC cycles before the next command.
- R5: The final command is LOAD MODE REGISTER (encoding 0000) with bank zero. Its address holds burst length in bits 2:0, burst type in bit 3, CAS latency in bits 6:4 (only 010 for 2 or 011 for 3 allowed), 00 in bits 8:7, write-burst mode in bit 9, and zero in bits 12:10.
- R6: `init_done` rises exactly T_MRD_CYC cycles after LOAD MODE REGISTER and stays high until the next reset, which clears it at once.
- R7: Before `init_done`, clock enable is high in every cycle and no encoding other than NOP, PRECHARGE, AUTO REFRESH or LOAD MODE REGISTER appears.
- R8: Before `init_done`, the controller-side inputs have no effect on the bus. From the cycle `init_done` is high, every bus output equals the matching controller input in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_cke | input | 1 | Clock enable from the normal controller |
| ctl_cs_n | input | 1 | Chip select from the normal controller |
| ctl_ras_n | input | 1 | Row strobe from the normal controller |
| ctl_cas_n | input | 1 | Column strobe from the normal controller |
| ctl_we_n | input | 1 | Write enable from the normal controller |
| ctl_ba | input | BA_W | Bank address from the normal controller |
| ctl_addr | input | ADDR_W | Address from the normal controller |
| mem_cke | output | 1 | Clock enable to the memory |
| mem_cs_n | output | 1 | Chip select to the memory |
| mem_ras_n | output | 1 | Row strobe to the memory |
| mem_cas_n | output | 1 | Column strobe to the memory |
| mem_we_n | output | 1 | Write enable to the memory |
| mem_ba | output | BA_W | Bank address to the memory |
| mem_addr | output | ADDR_W | Address / op-code to the memory |
| init_done | output | 1 | Bring-up complete; the bus now follows the controller |

## Verification
The checker assumes that reset is held for at least one clock edge. It also assumes that the controller-side inputs are stable around the sampling edge once `init_done` is high, because the handover path is purely combinational. The bench holds reset for several cycles. It parks the controller inputs on an ACTIVE-like pattern with clock enable low during bring-up, so any leakage through the multiplexer would show. It changes those inputs only on falling edges. Parameters stay within the legal set (gaps of two or more cycles, CAS latency 2 or 3), which the elaboration checks enforce.

// File: rtl/sdram_bringup_pkg.sv
package sdram_bringup_pkg;

   // {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_LMR = 4'b0000,
      CMD_REF = 4'b0001,
      CMD_PRE = 4'b0010,
      CMD_NOP = 4'b0111
   } sdr_cmd_e;

   typedef enum logic [2:0] {
      ST_PWR,
      ST_PRE,
      ST_REF,
      ST_LMR,
      ST_GAP,
      ST_DONE
   } seq_state_e;

   localparam int unsigned OP_W = 13;

   function automatic logic [OP_W-1:0] build_mode_op(
      input logic [2:0] len_code,
      input logic       interleave,
      input logic [2:0] cas_code,
      input logic       wr_single
   );
      build_mode_op = {3'b000, wr_single, 2'b00, cas_code, interleave, len_code};
   endfunction

endpackage

// File: rtl/sdram_bringup_timer.sv
module sdram_bringup_timer #(
   parameter int unsigned CNT_W   = 8,
   parameter int unsigned RST_VAL = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= CNT_W'(RST_VAL);
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/sdram_bringup_fsm.sv
module sdram_bringup_fsm
   import sdram_bringup_pkg::*;
#(
   parameter int unsigned CNT_W     = 8,
   parameter int unsigned T_RP_CYC  = 3,
   parameter int unsigned T_RFC_CYC = 9,
   parameter int unsigned T_MRD_CYC = 2,
   parameter int unsigned REF_N     = 2,
   parameter logic [OP_W-1:0] MODE_OP = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tmr_expired,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output sdr_cmd_e         seq_cmd,
   output logic [OP_W-1:0]  seq_addr,
   output logic             seq_done
);
   localparam int unsigned REF_W = (REF_N > 1) ? $clog2(REF_N) : 1;
   localparam logic [REF_W-1:0] REF_LAST = REF_W'(REF_N - 1);

   seq_state_e       state_q, state_d, ret_q, ret_d;
   logic [REF_W-1:0] ref_q, ref_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_PWR;
         ret_q   <= ST_PRE;
         ref_q   <= '0;
      end else begin
         state_q <= state_d;
         ret_q   <= ret_d;
         ref_q   <= ref_d;
      end
   end

   always_comb begin
      state_d  = state_q;
      ret_d    = ret_q;
      ref_d    = ref_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (state_q)
         ST_PWR:  if (tmr_expired) state_d = ST_PRE;
         ST_PRE: begin
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(T_RP_CYC - 2);
            ret_d    = ST_REF;
            state_d  = ST_GAP;
         end
         ST_REF: begin
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(T_RFC_CYC - 2);
            ref_d    = ref_q + 1'b1;
            ret_d    = (ref_q == REF_LAST) ? ST_LMR : ST_REF;
            state_d  = ST_GAP;
         end
         ST_LMR: begin
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(T_MRD_CYC - 2);
            ret_d    = ST_DONE;
            state_d  = ST_GAP;
         end
         ST_GAP:  if (tmr_expired) state_d = ret_q;
         ST_DONE: state_d = ST_DONE;
         default: state_d = ST_PWR;
      endcase
   end

   always_comb begin
      seq_cmd  = CMD_NOP;
      seq_addr = '0;
      case (state_q)
         ST_PRE: begin
            seq_cmd      = CMD_PRE;
            seq_addr[10] = 1'b1;
         end
         ST_REF: seq_cmd = CMD_REF;
         ST_LMR: begin
            seq_cmd  = CMD_LMR;
            seq_addr = MODE_OP;
         end
         default: ;
      endcase
   end

   assign seq_done = (state_q == ST_DONE);
endmodule

// File: rtl/sdram_bringup_mux.sv
module sdram_bringup_mux
   import sdram_bringup_pkg::*;
#(
   parameter int unsigned ADDR_W = 13,
   parameter int unsigned BA_W   = 2
) (
   input  logic              sel_ctl,
   input  sdr_cmd_e          seq_cmd,
   input  logic [ADDR_W-1:0] seq_addr,
   input  logic              ctl_cke,
   input  logic              ctl_cs_n,
   input  logic              ctl_ras_n,
   input  logic              ctl_cas_n,
   input  logic              ctl_we_n,
   input  logic [BA_W-1:0]   ctl_ba,
   input  logic [ADDR_W-1:0] ctl_addr,
   output logic              mem_cke,
   output logic              mem_cs_n,
   output logic              mem_ras_n,
   output logic              mem_cas_n,
   output logic              mem_we_n,
   output logic [BA_W-1:0]   mem_ba,
   output logic [ADDR_W-1:0] mem_addr
);
   always_comb begin
      if (sel_ctl) begin
         mem_cke   = ctl_cke;
         {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = {ctl_cs_n, ctl_ras_n, ctl_cas_n, ctl_we_n};
         mem_ba    = ctl_ba;
         mem_addr  = ctl_addr;
      end else begin
         mem_cke   = 1'b1;
         {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = seq_cmd;
         mem_ba    = '0;
         mem_addr  = seq_addr;
      end
   end
endmodule

// File: rtl/sdram_bringup_seq.sv
module sdram_bringup_seq
   import sdram_bringup_pkg::*;
#(
   parameter int unsigned CLK_MHZ      = 133,
   parameter int unsigned PWRUP_US     = 100,
   parameter int unsigned SIM_WAIT_CYC = 0,
   parameter int unsigned T_RP_CYC     = 3,
   parameter int unsigned T_RFC_CYC    = 9,
   parameter int unsigned T_MRD_CYC    = 2,
   parameter int unsigned REF_N        = 2,
   parameter int unsigned ADDR_W       = 13,
   parameter int unsigned BA_W         = 2,
   parameter logic [2:0]  BL_CODE      = 3'd3,
   parameter logic        BURST_IL     = 1'b0,
   parameter int unsigned CAS_LAT      = 3,
   parameter logic        WR_SINGLE    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_cke,
   input  logic              ctl_cs_n,
   input  logic              ctl_ras_n,
   input  logic              ctl_cas_n,
   input  logic              ctl_we_n,
   input  logic [BA_W-1:0]   ctl_ba,
   input  logic [ADDR_W-1:0] ctl_addr,
   output logic              mem_cke,
   output logic              mem_cs_n,
   output logic              mem_ras_n,
   output logic              mem_cas_n,
   output logic              mem_we_n,
   output logic [BA_W-1:0]   mem_ba,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              init_done
);
   localparam int unsigned WAIT_CYC = (SIM_WAIT_CYC != 0) ? SIM_WAIT_CYC : CLK_MHZ * PWRUP_US;
   localparam int unsigned GAP_MAX  = (T_RFC_CYC > T_RP_CYC) ? T_RFC_CYC : T_RP_CYC;
   localparam int unsigned CNT_MAX  = (WAIT_CYC > GAP_MAX) ? WAIT_CYC : GAP_MAX;
   localparam int unsigned CNT_W    = $clog2(CNT_MAX + 1);
   localparam logic [OP_W-1:0] MODE_OP =
      build_mode_op(BL_CODE, BURST_IL, 3'(CAS_LAT), WR_SINGLE);

   // elaboration-time parameter checks
   if (!(CAS_LAT == 2 || CAS_LAT == 3)) begin : g_bad_cas
      $error("CAS_LAT must be 2 or 3");
   end
   if (!(BL_CODE <= 3'd3 || (BL_CODE == 3'd7 && !BURST_IL))) begin : g_bad_bl
      $error("BL_CODE must be 0..3, or 7 with sequential bursts");
   end
   if (T_RP_CYC < 2 || T_RFC_CYC < 2 || T_MRD_CYC < 2) begin : g_bad_gap
      $error("command gaps must be at least 2 cycles");
   end
   if (ADDR_W < OP_W || REF_N < 1 || WAIT_CYC < 1) begin : g_bad_shape
      $error("ADDR_W >= 13, REF_N >= 1 and a non-zero wait are required");
   end

   logic             tmr_expired, tmr_load;
   logic [CNT_W-1:0] tmr_val;
   sdr_cmd_e         seq_cmd;
   logic [OP_W-1:0]  seq_op_addr;
   logic [ADDR_W-1:0] seq_addr;

   sdram_bringup_timer #(.CNT_W(CNT_W), .RST_VAL(WAIT_CYC - 1)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   sdram_bringup_fsm #(
      .CNT_W     (CNT_W),
      .T_RP_CYC  (T_RP_CYC),
      .T_RFC_CYC (T_RFC_CYC),
      .T_MRD_CYC (T_MRD_CYC),
      .REF_N     (REF_N),
      .MODE_OP   (MODE_OP)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .tmr_expired (tmr_expired),
      .tmr_load    (tmr_load),
      .tmr_val     (tmr_val),
      .seq_cmd     (seq_cmd),
      .seq_addr    (seq_op_addr),
      .seq_done    (init_done)
   );

   // widen the op-code / precharge address onto a wider bus
   if (ADDR_W > OP_W) begin : g_addr_pad
      assign seq_addr = {{(ADDR_W-OP_W){1'b0}}, seq_op_addr};
   end else begin : g_addr_exact
      assign seq_addr = seq_op_addr;
   end

   sdram_bringup_mux #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_mux (
      .sel_ctl   (init_done),
      .seq_cmd   (seq_cmd),
      .seq_addr  (seq_addr),
      .ctl_cke   (ctl_cke),
      .ctl_cs_n  (ctl_cs_n),
      .ctl_ras_n (ctl_ras_n),
      .ctl_cas_n (ctl_cas_n),
      .ctl_we_n  (ctl_we_n),
      .ctl_ba    (ctl_ba),
      .ctl_addr  (ctl_addr),
      .mem_cke   (mem_cke),
      .mem_cs_n  (mem_cs_n),
      .mem_ras_n (mem_ras_n),
      .mem_cas_n (mem_cas_n),
      .mem_we_n  (mem_we_n),
      .mem_ba    (mem_ba),
      .mem_addr  (mem_addr)
   );
endmodule

// File: rtl/sdram_bringup_chk.sv
module sdram_bringup_chk #(
   parameter int unsigned T_RP_CYC  = 3,
   parameter int unsigned T_RFC_CYC = 9,
   parameter int unsigned T_MRD_CYC = 2,
   parameter int unsigned REF_N     = 2,
   parameter int unsigned ADDR_W    = 13,
   parameter int unsigned BA_W      = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ctl_cke,
   input logic              ctl_cs_n,
   input logic              ctl_ras_n,
   input logic              ctl_cas_n,
   input logic              ctl_we_n,
   input logic [BA_W-1:0]   ctl_ba,
   input logic [ADDR_W-1:0] ctl_addr,
   input logic              mem_cke,
   input logic              mem_cs_n,
   input logic              mem_ras_n,
   input logic              mem_cas_n,
   input logic              mem_we_n,
   input logic [BA_W-1:0]   mem_ba,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              init_done
);
   localparam logic [3:0] K_LMR = 4'b0000, K_REF = 4'b0001, K_PRE = 4'b0010, K_NOP = 4'b0111;

   logic [3:0]  bus_cmd;
   logic        issue;
   logic [15:0] gap_q;
   logic [15:0] need_q;
   logic        have_last_q, last_lmr_q;
   logic [7:0]  ref_seen_q;

   assign bus_cmd = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
   assign issue   = !init_done && (bus_cmd != K_NOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q       <= '0;
         need_q      <= '0;
         have_last_q <= 1'b0;
         last_lmr_q  <= 1'b0;
         ref_seen_q  <= '0;
      end else if (issue) begin
         gap_q       <= 16'd1;
         have_last_q <= 1'b1;
         last_lmr_q  <= (bus_cmd == K_LMR);
         need_q      <= (bus_cmd == K_PRE) ? 16'(T_RP_CYC) :
                        (bus_cmd == K_REF) ? 16'(T_RFC_CYC) : 16'(T_MRD_CYC);
         if (bus_cmd == K_REF) ref_seen_q <= ref_seen_q + 1'b1;
      end else if (gap_q != 16'hFFFF) begin
         gap_q <= gap_q + 1'b1;
      end
   end

   AST_CKE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !init_done |-> mem_cke); // R7
   AST_INIT_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      !init_done |-> (bus_cmd == K_NOP || bus_cmd == K_PRE || bus_cmd == K_REF || bus_cmd == K_LMR)); // R7
   AST_PRE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && !have_last_q) |-> (bus_cmd == K_PRE && mem_addr[10])); // R3
   AST_GAP_MET: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && have_last_q) |-> (gap_q == need_q)); // R4
   AST_REF_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && bus_cmd == K_LMR) |-> (ref_seen_q == 8'(REF_N))); // R4
   AST_MODE_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && bus_cmd == K_LMR) |->
         (mem_addr[8:7] == 2'b00 && mem_addr[12:10] == 3'b000 &&
          (mem_addr[6:4] == 3'd2 || mem_addr[6:4] == 3'd3) && mem_ba == '0)); // R5
   AST_DONE_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(init_done) |-> (last_lmr_q && gap_q == 16'(T_MRD_CYC))); // R6
   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done); // R6
   AST_HANDOVER: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |-> (mem_cke == ctl_cke && bus_cmd == {ctl_cs_n, ctl_ras_n, ctl_cas_n, ctl_we_n} &&
                     mem_ba == ctl_ba && mem_addr == ctl_addr)); // R8
endmodule

bind sdram_bringup_seq sdram_bringup_chk #(
   .T_RP_CYC  (T_RP_CYC),
   .T_RFC_CYC (T_RFC_CYC),
   .T_MRD_CYC (T_MRD_CYC),
   .REF_N     (REF_N),
   .ADDR_W    (ADDR_W),
   .BA_W      (BA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ctl_cke   (ctl_cke),
   .ctl_cs_n  (ctl_cs_n),
   .ctl_ras_n (ctl_ras_n),
   .ctl_cas_n (ctl_cas_n),
   .ctl_we_n  (ctl_we_n),
   .ctl_ba    (ctl_ba),
   .ctl_addr  (ctl_addr),
   .mem_cke   (mem_cke),
   .mem_cs_n  (mem_cs_n),
   .mem_ras_n (mem_ras_n),
   .mem_cas_n (mem_cas_n),
   .mem_we_n  (mem_we_n),
   .mem_ba    (mem_ba),
   .mem_addr  (mem_addr),
   .init_done (init_done)
);

// File: tb/sdram_bringup_seq_bench.sv
module sdram_bringup_seq_bench;
   localparam int unsigned CLK_MHZ = 50;
   localparam int unsigned W       = 50;
   localparam int unsigned T_RP    = 2;
   localparam int unsigned T_RFC   = 4;
   localparam int unsigned T_MRD   = 2;
   localparam int unsigned REF_N   = 2;
   localparam int unsigned AW      = 13;
   localparam int unsigned BW      = 2;
   localparam logic [2:0]  BL      = 3'd3;
   localparam logic        BT      = 1'b1;
   localparam int unsigned CAS     = 3;
   localparam logic        WBM     = 1'b1;

   localparam logic [3:0] E_LMR = 4'b0000, E_REF = 4'b0001, E_PRE = 4'b0010,
                          E_NOP = 4'b0111, E_DONE = 4'b1111;

   typedef struct {
      logic [3:0]    kind;
      int            cyc;
      logic [AW-1:0] addr;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctl_cke, ctl_cs_n, ctl_ras_n, ctl_cas_n, ctl_we_n;
   logic [BW-1:0] ctl_ba;
   logic [AW-1:0] ctl_addr;
   logic mem_cke, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, init_done;
   logic [BW-1:0] mem_ba;
   logic [AW-1:0] mem_addr;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   exp_t sb_q[$];
   bit done_seen = 0;

   always #10 clk = ~clk; // 50 MHz

   sdram_bringup_seq #(
      .CLK_MHZ(CLK_MHZ), .SIM_WAIT_CYC(W), .T_RP_CYC(T_RP), .T_RFC_CYC(T_RFC),
      .T_MRD_CYC(T_MRD), .REF_N(REF_N), .ADDR_W(AW), .BA_W(BW),
      .BL_CODE(BL), .BURST_IL(BT), .CAS_LAT(CAS), .WR_SINGLE(WBM)
   ) u_sdram_bringup_seq (
      .clk(clk), .rst_n(rst_n),
      .ctl_cke(ctl_cke), .ctl_cs_n(ctl_cs_n), .ctl_ras_n(ctl_ras_n),
      .ctl_cas_n(ctl_cas_n), .ctl_we_n(ctl_we_n), .ctl_ba(ctl_ba), .ctl_addr(ctl_addr),
      .mem_cke(mem_cke), .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n),
      .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n), .mem_ba(mem_ba), .mem_addr(mem_addr),
      .init_done(init_done)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // driver side: expected command stream computed from the requirements
   task automatic push_expected();
      exp_t e;
      int t;
      logic [AW-1:0] op;
      op = '0;
      op[2:0] = BL;  op[3] = BT;  op[6:4] = 3'(CAS);  op[9] = WBM;
      t = W;
      e.kind = E_PRE; e.cyc = t; e.addr = AW'(1) << 10; sb_q.push_back(e);   // R2 R3
      t += T_RP;
      for (int i = 0; i < REF_N; i++) begin
         e.kind = E_REF; e.cyc = t; e.addr = '0; sb_q.push_back(e);           // R4
         t += T_RFC;
      end
      e.kind = E_LMR; e.cyc = t; e.addr = op; sb_q.push_back(e);              // R5
      t += T_MRD;
      e.kind = E_DONE; e.cyc = t; e.addr = '0; sb_q.push_back(e);             // R6
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   // monitor: pops expectations as the design emits commands
   always @(negedge clk) begin
      logic [3:0] c;
      exp_t e;
      c = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
      if (!rst_n) begin
         done_seen = 0;
      end else if (!init_done) begin
         check(mem_cke == 1'b1, "R7", "cke during bring-up", mem_cke, 1);
         if (c != E_NOP) begin
            if (sb_q.size() == 0) begin
               check(0, "R7", "unexpected command", c, E_NOP);
            end else begin
               e = sb_q.pop_front();
               check(c == e.kind, "R3", "command order", c, e.kind);
               check(cyc == e.cyc, "R4", "command cycle", cyc, e.cyc);
               check(mem_addr == e.addr, "R5", "command address", mem_addr, e.addr);
               check(mem_ba == '0, "R5", "command bank", mem_ba, 0);
               if (c == E_LMR)
                  check(mem_addr[6:4] == 3'd2 || mem_addr[6:4] == 3'd3, "R5",
                        "CAS latency code", mem_addr[6:4], CAS);
            end
         end else begin
            check(mem_addr == '0 && mem_ba == '0, "R8", "idle bus ignores controller",
                  mem_addr, 0);
         end
      end else if (!done_seen) begin
         done_seen = 1;
         if (sb_q.size() == 0) begin
            check(0, "R6", "done without expectation", cyc, 0);
         end else begin
            e = sb_q.pop_front();
            check(e.kind == E_DONE, "R6", "done before all commands", e.kind, E_DONE);
            check(cyc == e.cyc, "R6", "done cycle", cyc, e.cyc);
         end
      end
   end

   task automatic park_controller();
      // ACTIVE-like pattern with clock enable low: must not reach the bus early (R8)
      ctl_cke = 1'b0; ctl_cs_n = 1'b0; ctl_ras_n = 1'b0; ctl_cas_n = 1'b1;
      ctl_we_n = 1'b1; ctl_ba = 2'b11; ctl_addr = '1;
   endtask

   task automatic check_reset_state();
      check({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} == E_NOP, "R1", "reset command",
            {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n}, E_NOP);
      check(mem_cke == 1'b1, "R1", "reset cke", mem_cke, 1);
      check(init_done == 1'b0, "R1", "reset done", init_done, 0);
      check(mem_addr == '0 && mem_ba == '0, "R1", "reset address", mem_addr, 0);
   endtask

   task automatic run_bringup();
      park_controller();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check_reset_state();
      push_expected();
      rst_n = 1'b1;
      while (!init_done) @(negedge clk);
      repeat (2) @(negedge clk);
      check(sb_q.size() == 0, "R4", "all expected commands seen", sb_q.size(), 0);
   endtask

   initial begin
      fork
         begin
            run_bringup();
            // R6: done holds
            for (int i = 0; i < 10; i++) begin
               @(negedge clk);
               check(init_done == 1'b1, "R6", "done held", init_done, 1);
            end
            // R8: handover follows controller in the same cycle
            for (int i = 0; i < 4; i++) begin
               @(negedge clk);
               ctl_cke = i[0]; ctl_cs_n = i[1]; ctl_ras_n = ~i[0]; ctl_cas_n = i[0] ^ i[1];
               ctl_we_n = ~i[1]; ctl_ba = 2'(i); ctl_addr = AW'(13'h0A5 * (i + 3));
               #1;
               check({mem_cke, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} ==
                     {ctl_cke, ctl_cs_n, ctl_ras_n, ctl_cas_n, ctl_we_n},
                     "R8", "handover control", {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n},
                     {ctl_cs_n, ctl_ras_n, ctl_cas_n, ctl_we_n});
               check(mem_addr == ctl_addr && mem_ba == ctl_ba, "R8", "handover address",
                     mem_addr, ctl_addr);
            end
            // R6: reset clears done immediately, then the sequence restarts
            @(negedge clk);
            rst_n = 1'b0;
            #1;
            check(init_done == 1'b0, "R6", "done cleared by reset", init_done, 0);
            check_reset_state();
            run_bringup();
         end
         begin
            repeat (20000) @(posedge clk);
            check(0, "R2", "watchdog expired", cyc, 0);
         end
      join_any
      disable fork;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule